// File: doc/BRIEF.md
# Dual-Path Registered Bus Driver

This block drives a 12-bit data bus onto two identical output buses through one of two paths. In the registered path the input bus is sampled into an internal register on the rising clock edge and the outputs show the stored word. In the bypass path the input bus reaches the outputs combinationally, with no clock involved. A mode input picks the path and may change at any time, including in the middle of a data stream.

An active-low clock enable gates only the lower eight bits of the register. When it is deasserted, the upper four bits still load on every edge and the lower eight keep their value. The register follows these loading rules in both modes, so returning to the registered path shows whatever the last edges captured. Bit index 10 is an ordinary data bit here, although a neighbouring parity block also reads it as its error-output enable.

An active-low output enable controls both output copies. High impedance is modelled by an explicit per-bus enable flag rather than by driving 'z'. A disabled bus shows all zeros on its data lines. The path selection is named as two states: PATH_REG, taken when mode is 0, and PATH_BYPASS, taken when mode is 1. Moving from one state to the other is purely combinational, in either direction.

Top module: `bdrv_dual_path`

## Requirements
- R1: A synchronous active-high reset clears all 12 register bits to zero at the rising edge, whatever the state of the clock enable. With mode 0 and outputs enabled, both buses then read 0.
- R2: With mode 0 and the clock enable low, all 12 input bits are captured at the rising edge. Both buses show the captured word from that edge onward.
- R3: With the clock enable high, bits [11:8] (including bit 10) are still captured at each rising edge, while bits [7:0] keep their stored value.
- R4: With mode 1, both buses equal the input bus in the same cycle, with no clock edge needed.
- R5: The register keeps loading under the R2 and R3 rules while mode is 1. After a switch back to mode 0, the outputs show the last captured word.
- R6: The two output buses always carry identical data and identical enable flags.
- R7: With the output enable high, both enable flags are 0 and both data buses read zero. With it low, both flags are 1.
- R8: The output enable has no effect on the register. A word captured while the outputs are disabled appears once they are enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the register |
| a_bus | input | 12 | Input data bus |
| clk_en_n | input | 1 | Active-low enable for register bits [7:0] |
| mode | input | 1 | 0 selects the registered path, 1 selects bypass |
| oe_n | input | 1 | Active-low output enable for both buses |
| y1 | output | 12 | First output copy |
| y1_en | output | 1 | Drive flag for y1 (0 models high impedance) |
| y2 | output | 12 | Second output copy |
| y2_en | output | 1 | Drive flag for y2 (0 models high impedance) |

## Verification
The hardest case to reach from the ports is a register that kept loading while the outputs could not show it. This happens in bypass mode, and while the outputs are disabled. In both cases the stored word is hidden until the mode or the enable changes. The stimulus table therefore loads a full word in bypass mode, then returns to mode 0 with the clock enable high. The check sees new upper bits over lower bits that came from the bypass cycle. A second sequence captures while the outputs are disabled and reads the result back once they are enabled.

// File: rtl/bdrv_pkg.sv
package bdrv_pkg;

    // Which path feeds the output buses.
    typedef enum logic {
        PATH_REG    = 1'b0,
        PATH_BYPASS = 1'b1
    } path_sel_e;

    function automatic path_sel_e decode_mode(input logic mode_bit);
        return mode_bit ? PATH_BYPASS : PATH_REG;
    endfunction

endpackage

// File: rtl/bdrv_capture.sv
module bdrv_capture #(
    parameter int W      = 12,
    parameter int HOLD_W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_low,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int UP_W = W - HOLD_W;

    logic [HOLD_W-1:0] low_q;
    logic [UP_W-1:0]   up_q;

    // Upper group loads on every edge.
    always_ff @(posedge clk) begin
        if (rst) up_q <= '0;
        else     up_q <= d[W-1:HOLD_W];
    end

    // Lower group loads only when the enable is active.
    always_ff @(posedge clk) begin
        if (rst)           low_q <= '0;
        else if (load_low) low_q <= d[HOLD_W-1:0];
    end

    assign q = {up_q, low_q};

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> q == '0);

    assert_load_all_R2: assert property (@(posedge clk) disable iff (rst)
        load_low |=> q == $past(d));

    assert_upper_load_R3: assert property (@(posedge clk) disable iff (rst)
        !load_low |=> q[W-1:HOLD_W] == $past(d[W-1:HOLD_W]));

    assert_lower_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !load_low |=> q[HOLD_W-1:0] == $past(q[HOLD_W-1:0]));

endmodule

// File: rtl/bdrv_path_mux.sv
module bdrv_path_mux
    import bdrv_pkg::*;
#(
    parameter int W = 12
) (
    input  path_sel_e    sel,
    input  logic [W-1:0] reg_q,
    input  logic [W-1:0] bypass_d,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            PATH_REG:    y = reg_q;
            PATH_BYPASS: y = bypass_d;
        endcase
    end
endmodule

// File: rtl/bdrv_fanout.sv
module bdrv_fanout #(
    parameter int W      = 12,
    parameter int COPIES = 2
) (
    input  logic                      oe_n,
    input  logic [W-1:0]              d,
    output logic [COPIES-1:0][W-1:0]  y,
    output logic [COPIES-1:0]         en
);
    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        always_comb begin
            en[c] = ~oe_n;
            y[c]  = oe_n ? '0 : d;
        end
    end
endmodule

// File: rtl/bdrv_dual_path.sv
module bdrv_dual_path
    import bdrv_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_bus,
    input  logic              clk_en_n,
    input  logic              mode,
    input  logic              oe_n,
    output logic [DATA_W-1:0] y1,
    output logic              y1_en,
    output logic [DATA_W-1:0] y2,
    output logic              y2_en
);
    localparam int COPIES = 2;

    logic [DATA_W-1:0]             reg_q;
    logic [DATA_W-1:0]             sel_y;
    logic [COPIES-1:0][DATA_W-1:0] fan_y;
    logic [COPIES-1:0]             fan_en;
    path_sel_e                     path;

    assign path = decode_mode(mode);

    bdrv_capture #(.W(DATA_W), .HOLD_W(HOLD_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .load_low (~clk_en_n),
        .d        (a_bus),
        .q        (reg_q)
    );

    bdrv_path_mux #(.W(DATA_W)) u_mux (
        .sel      (path),
        .reg_q    (reg_q),
        .bypass_d (a_bus),
        .y        (sel_y)
    );

    bdrv_fanout #(.W(DATA_W), .COPIES(COPIES)) u_fanout (
        .oe_n (oe_n),
        .d    (sel_y),
        .y    (fan_y),
        .en   (fan_en)
    );

    assign y1    = fan_y[0];
    assign y2    = fan_y[1];
    assign y1_en = fan_en[0];
    assign y2_en = fan_en[1];

    assert_bypass_R4: assert property (@(posedge clk) disable iff (rst)
        (mode && !oe_n) |-> y1 == a_bus);

    assert_reg_path_R2: assert property (@(posedge clk) disable iff (rst)
        !clk_en_n |=> (mode || oe_n || y1 == $past(a_bus)));

    assert_copies_R6: assert property (@(posedge clk)
        (y1 == y2) && (y1_en == y2_en));

    assert_disabled_R7: assert property (@(posedge clk)
        oe_n |-> (y1 == '0 && !y1_en && !y2_en));

endmodule

// File: tb/bdrv_dual_path_bench.sv
module bdrv_dual_path_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] a_bus = '0;
    logic        clk_en_n = 1'b0;
    logic        mode = 1'b0;
    logic        oe_n = 1'b0;
    logic [11:0] y1, y2;
    logic        y1_en, y2_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    bdrv_dual_path u_bdrv_dual_path (
        .clk(clk), .rst(rst), .a_bus(a_bus), .clk_en_n(clk_en_n),
        .mode(mode), .oe_n(oe_n), .y1(y1), .y1_en(y1_en),
        .y2(y2), .y2_en(y2_en)
    );

    // {mode, clk_en_n, oe_n, a_bus, expected y, expected enable}
    localparam logic [27:0] VEC [12] = '{
        {1'b0, 1'b0, 1'b0, 12'hA5C, 12'hA5C, 1'b1}, // R2 full load
        {1'b0, 1'b1, 1'b0, 12'h3F1, 12'h35C, 1'b1}, // R3 upper only
        {1'b0, 1'b1, 1'b0, 12'hEAA, 12'hE5C, 1'b1}, // R3 low bits change, held
        {1'b1, 1'b0, 1'b0, 12'h123, 12'h123, 1'b1}, // R4 bypass, reg loads 123
        {1'b0, 1'b1, 1'b0, 12'h9FF, 12'h923, 1'b1}, // R5 back to reg path
        {1'b0, 1'b0, 1'b1, 12'h456, 12'h000, 1'b0}, // R7 disabled, reg loads 456
        {1'b0, 1'b1, 1'b0, 12'hB00, 12'hB56, 1'b1}, // R8 hidden capture shown
        {1'b1, 1'b1, 1'b1, 12'hFFF, 12'h000, 1'b0}, // R7 disabled in bypass
        {1'b1, 1'b1, 1'b0, 12'h0C3, 12'h0C3, 1'b1}, // R4 bypass, reg 056
        {1'b0, 1'b1, 1'b0, 12'h400, 12'h456, 1'b1}, // R5 bypass kept low bits
        {1'b0, 1'b0, 1'b0, 12'h000, 12'h000, 1'b1}, // R2 all zero
        {1'b0, 1'b1, 1'b0, 12'hFFF, 12'hF00, 1'b1}  // R3 bit 10 in upper group
    };

    task automatic check(input string req, input logic [11:0] exp_y, input logic exp_en);
        n_checks++;
        if (y1 !== exp_y || y2 !== exp_y || y1_en !== exp_en || y2_en !== exp_en) begin
            n_fail++;
            $display("FAIL %s: y1=%h y2=%h en=%b/%b expected y=%h en=%b",
                     req, y1, y2, y1_en, y2_en, exp_y, exp_en);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1", 12'h000, 1'b1);
        rst = 1'b0;

        // Table walk: apply at negedge, sample at following negedge.
        foreach (VEC[i]) begin
            mode     = VEC[i][27];
            clk_en_n = VEC[i][26];
            oe_n     = VEC[i][25];
            a_bus    = VEC[i][24:13];
            @(negedge clk);
            check($sformatf("R2/R3/R4/R5/R6/R7/R8 row %0d", i), VEC[i][12:1], VEC[i][0]);
        end
        // Register now holds F00.

        // R4: bypass without a clock edge, mid-phase
        #1;
        mode = 1'b1; a_bus = 12'h5A5; clk_en_n = 1'b1;
        #1;
        check("R4 same cycle", 12'h5A5, 1'b1);
        mode = 1'b0;
        #1;
        check("R5 reg restored without edge", 12'hF00, 1'b1);
        @(negedge clk);
        check("R3 upper from 5A5", 12'h500, 1'b1);

        // R7: enable toggled with no edge
        oe_n = 1'b1;
        #1;
        check("R7 disable immediate", 12'h000, 1'b0);
        oe_n = 1'b0;
        #1;
        check("R8 enable restores", 12'h500, 1'b1);

        // R1: reset overrides a deasserted clock enable
        @(negedge clk);
        rst = 1'b1; clk_en_n = 1'b1; a_bus = 12'hFFF;
        @(negedge clk);
        check("R1 reset with hold", 12'h000, 1'b1);
        rst = 1'b0; clk_en_n = 1'b1; a_bus = 12'h0FF;
        @(negedge clk);
        check("R3 lower held after reset", 12'h000, 1'b1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule